// File: doc/BRIEF.md
# Accumulator ALU with Carry Rotates

A purely combinational arithmetic and logic unit for a small accumulator-style processor core. It takes two operands, a carry input and a four-bit operation select. In the same cycle it produces a result, a carry output and a zero flag. Instruction decoding and the status register that stores the flags belong to the surrounding core. The ALU only computes the values that the core may choose to write back.

The operation set covers the following:
- addition and subtraction, where the subtraction carry means "no borrow";
- bitwise AND, OR and XOR;
- one's complement of the first operand;
- nibble swap of the first operand;
- single-bit rotates left and right, passing through the carry.

Operations that have no carry meaning of their own copy the incoming carry to the carry output. A core that always writes the carry back therefore keeps its stored value. Unassigned operation codes behave the same way and return the first operand unchanged.

Top module: `accum_alu`

## Requirements
- R1: Operation code 0x0 (add) gives result = (A + B) mod 256, and carry out = bit 8 of the 9-bit sum.
- R2: Operation code 0x1 (subtract) gives result = (A - B) mod 256, and carry out = 1 exactly when A >= B (no borrow).
- R3: Operation codes 0x2, 0x3 and 0x4 give A AND B, A OR B and A XOR B respectively, each with carry out = carry in.
- R4: Operation code 0x5 gives the bitwise inverse of A with carry out = carry in. B has no effect on any output.
- R5: Operation code 0x6 (rotate right through carry) gives result = {carry in, A[7:1]} and carry out = A[0].
- R6: Operation code 0x7 (rotate left through carry) gives result = {A[6:0], carry in} and carry out = A[7].
- R7: Operation code 0x8 (nibble swap) gives result = {A[3:0], A[7:4]} with carry out = carry in.
- R8: For every operation code, the zero flag is 1 exactly when the 8-bit result is 0x00.
- R9: Operation codes 0x9 through 0xF return A unchanged with carry out = carry in.
- R10: Add and subtract ignore carry in. With the same A and B, the result and carry out are identical for carry in 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 4 | Operation code (encodings as listed in the requirements) |
| operandA | input | 8 | First operand; the only source for complement, rotates, swap and pass |
| operandB | input | 8 | Second operand for add, subtract and the logic functions |
| carryIn | input | 1 | Incoming carry, used by the rotates and copied by carry-neutral operations |
| result | output | 8 | Operation result |
| carryOut | output | 1 | Carry produced, or carry in passed through |
| zeroFlag | output | 1 | High when result is 0x00 |

## Verification
The zero flag is hard to reach through purely random operands. Random stimulus almost never yields an all-zero result, and for the rotates a zero result also depends on the carry input. Directed vectors therefore force zero through wrapping add, equal-operand subtract, complement of 0xFF, a rotate of a single set bit with carry in cleared, and AND of disjoint patterns. The boundary between borrow and no borrow in subtraction (A equal to B, and A one below B) is also driven directly. Random stimulus with a fixed seed then covers all sixteen codes, both carry values, and operand B changing under operations that must ignore it.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  localparam int DATA_W = 8;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_ADD  = 4'h0;
  localparam logic [OP_W-1:0] OP_SUB  = 4'h1;
  localparam logic [OP_W-1:0] OP_AND  = 4'h2;
  localparam logic [OP_W-1:0] OP_OR   = 4'h3;
  localparam logic [OP_W-1:0] OP_XOR  = 4'h4;
  localparam logic [OP_W-1:0] OP_COM  = 4'h5;
  localparam logic [OP_W-1:0] OP_ROR  = 4'h6;
  localparam logic [OP_W-1:0] OP_ROL  = 4'h7;
  localparam logic [OP_W-1:0] OP_SWAP = 4'h8;

  typedef enum logic [3:0] {
    RES_SUM,
    RES_AND,
    RES_OR,
    RES_XOR,
    RES_COM,
    RES_ROR,
    RES_ROL,
    RES_SWAP,
    RES_PASS
  } resSel_e;

  typedef enum logic [1:0] {
    CY_KEEP,
    CY_ADDER,
    CY_LSB,
    CY_MSB
  } cySel_e;

  typedef struct packed {
    resSel_e resSel;
    cySel_e  cySel;
    logic    invertB;
  } aluStrobes_t;

endpackage

// File: rtl/accum_alu_ctrl.sv
module accum_alu_ctrl
  import accum_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes.resSel  = RES_PASS;
    strobes.cySel   = CY_KEEP;
    strobes.invertB = 1'b0;
    unique case (opSel)
      OP_ADD: begin
        strobes.resSel = RES_SUM;
        strobes.cySel  = CY_ADDER;
      end
      OP_SUB: begin
        strobes.resSel  = RES_SUM;
        strobes.cySel   = CY_ADDER;
        strobes.invertB = 1'b1;
      end
      OP_AND:  strobes.resSel = RES_AND;
      OP_OR:   strobes.resSel = RES_OR;
      OP_XOR:  strobes.resSel = RES_XOR;
      OP_COM:  strobes.resSel = RES_COM;
      OP_ROR: begin
        strobes.resSel = RES_ROR;
        strobes.cySel  = CY_LSB;
      end
      OP_ROL: begin
        strobes.resSel = RES_ROL;
        strobes.cySel  = CY_MSB;
      end
      OP_SWAP: strobes.resSel = RES_SWAP;
      default: begin
        strobes.resSel = RES_PASS;
        strobes.cySel  = CY_KEEP;
      end
    endcase
  end

  // R2: only the subtract path inverts B
  always_comb begin
    a_r2_invert_only_sub : assert (!strobes.invertB || opSel == OP_SUB)
      else $error("invertB raised for op %h", opSel);
  end

endmodule

// File: rtl/accum_alu_datapath.sv
module accum_alu_datapath
  import accum_alu_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  aluStrobes_t      strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             cyIn,
  output logic [WIDTH-1:0] res,
  output logic             cyOut,
  output logic             zero
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] swapped;

  assign bEff    = strobes.invertB ? ~opB : opB;
  assign sumWide = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, strobes.invertB};

  generate
    if (WIDTH % 2 == 0) begin : g_swapEven
      assign swapped = {opA[HALF-1:0], opA[WIDTH-1:HALF]};
    end else begin : g_swapOdd
      assign swapped = opA;
    end
  endgenerate

  always_comb begin
    unique case (strobes.resSel)
      RES_SUM:  res = sumWide[WIDTH-1:0];
      RES_AND:  res = opA & opB;
      RES_OR:   res = opA | opB;
      RES_XOR:  res = opA ^ opB;
      RES_COM:  res = ~opA;
      RES_ROR:  res = {cyIn, opA[WIDTH-1:1]};
      RES_ROL:  res = {opA[WIDTH-2:0], cyIn};
      RES_SWAP: res = swapped;
      default:  res = opA;
    endcase
  end

  always_comb begin
    unique case (strobes.cySel)
      CY_ADDER: cyOut = sumWide[WIDTH];
      CY_LSB:   cyOut = opA[0];
      CY_MSB:   cyOut = opA[WIDTH-1];
      default:  cyOut = cyIn;
    endcase
  end

  assign zero = (res == '0);

  // R8: a nonzero result never reports zero
  always_comb begin
    a_r8_zero_vs_bits : assert (!(zero && (|res)))
      else $error("zero flag with nonzero result %h", res);
  end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
(
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              zeroFlag
);

  aluStrobes_t strobes;

  accum_alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  accum_alu_datapath #(.WIDTH(DATA_W)) u_dp (
    .strobes (strobes),
    .opA     (operandA),
    .opB     (operandB),
    .cyIn    (carryIn),
    .res     (result),
    .cyOut   (carryOut),
    .zero    (zeroFlag)
  );

  always_comb begin
    // R5: right rotate moves bit 0 into carry
    if (opSel == OP_ROR) begin
      a_r5_ror_carry : assert (carryOut == operandA[0] && result[DATA_W-1] == carryIn)
        else $error("ror mismatch");
    end
    // R6: left rotate moves the top bit into carry
    if (opSel == OP_ROL) begin
      a_r6_rol_carry : assert (carryOut == operandA[DATA_W-1] && result[0] == carryIn)
        else $error("rol mismatch");
    end
    // R2: subtract carry is the no-borrow indication
    if (opSel == OP_SUB) begin
      a_r2_sub_noborrow : assert (carryOut == (operandA >= operandB))
        else $error("sub carry mismatch");
    end
    // R3, R4, R7, R9: carry-neutral codes preserve the incoming carry
    if (opSel >= OP_AND && opSel != OP_ROR && opSel != OP_ROL) begin
      a_r9_carry_kept : assert (carryOut == carryIn)
        else $error("carry not preserved for op %h", opSel);
    end
  end

endmodule

// File: tb/accum_alu_tb.sv
`timescale 1ns/1ps
module accum_alu_tb;

  logic       clk = 1'b0;
  logic [3:0] opSel = 4'h0;
  logic [7:0] operandA = 8'h00;
  logic [7:0] operandB = 8'h00;
  logic       carryIn = 1'b0;
  logic [7:0] result;
  logic       carryOut;
  logic       zeroFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  accum_alu u_dut (
    .opSel    (opSel),
    .operandA (operandA),
    .operandB (operandB),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut),
    .zeroFlag (zeroFlag)
  );

  function automatic logic [9:0] model(input logic [3:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic c);
    logic [7:0] r;
    logic       co;
    logic [8:0] s;
    co = c;
    case (op)
      4'h0: begin s = {1'b0, a} + {1'b0, b}; r = s[7:0]; co = s[8]; end
      4'h1: begin r = a - b; co = (a >= b); end
      4'h2: r = a & b;
      4'h3: r = a | b;
      4'h4: r = a ^ b;
      4'h5: r = ~a;
      4'h6: begin r = {c, a[7:1]}; co = a[0]; end
      4'h7: begin r = {a[6:0], c}; co = a[7]; end
      4'h8: r = {a[3:0], a[7:4]};
      default: r = a;
    endcase
    return {(r == 8'h00), co, r};
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2, 4'h3, 4'h4: return "R3";
      4'h5: return "R4";
      4'h6: return "R5";
      4'h7: return "R6";
      4'h8: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic applyCheck(input logic [3:0] op, input logic [7:0] a,
                            input logic [7:0] b, input logic c, input string tag);
    logic [9:0] exp;
    @(negedge clk);
    opSel = op; operandA = a; operandB = b; carryIn = c;
    #2;
    exp = model(op, a, b, c);
    checks++;
    if (result !== exp[7:0] || carryOut !== exp[8]) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h c=%b: got res=%h cy=%b, expected res=%h cy=%b",
               tag, op, a, b, c, result, carryOut, exp[7:0], exp[8]);
    end
    checks++;
    if (zeroFlag !== exp[9]) begin
      errors++;
      $display("FAIL R8 op=%h a=%h b=%h: got zero=%b, expected zero=%b",
               op, a, b, zeroFlag, exp[9]);
    end
  endtask

  initial begin
    int unsigned seed;
    logic [7:0] rA, rB;
    logic [3:0] rOp;
    logic rC;
    logic [8:0] keep0;
    seed = 32'd12345;
    void'($urandom(seed));
    @(negedge clk);
    #2;
    checks++;
    if (result !== 8'h00 || carryOut !== 1'b0 || zeroFlag !== 1'b1) begin
      errors++;
      $display("FAIL R1 initial: got res=%h cy=%b z=%b, expected res=00 cy=0 z=1",
               result, carryOut, zeroFlag);
    end
    applyCheck(4'h0, 8'hFF, 8'h01, 1'b0, "R1");
    applyCheck(4'h0, 8'h12, 8'h34, 1'b0, "R1");
    applyCheck(4'h1, 8'h05, 8'h05, 1'b0, "R2");
    applyCheck(4'h1, 8'h03, 8'h04, 1'b1, "R2");
    applyCheck(4'h1, 8'h00, 8'hFF, 1'b0, "R2");
    applyCheck(4'h2, 8'hF0, 8'h0F, 1'b1, "R3");
    applyCheck(4'h3, 8'hA0, 8'h05, 1'b0, "R3");
    applyCheck(4'h4, 8'h5A, 8'h5A, 1'b1, "R3");
    applyCheck(4'h5, 8'hFF, 8'h00, 1'b0, "R4");
    applyCheck(4'h5, 8'hFF, 8'hC3, 1'b1, "R4");
    applyCheck(4'h6, 8'h01, 8'h00, 1'b0, "R5");
    applyCheck(4'h6, 8'h80, 8'h00, 1'b1, "R5");
    applyCheck(4'h7, 8'h80, 8'h00, 1'b1, "R6");
    applyCheck(4'h7, 8'h80, 8'h00, 1'b0, "R6");
    applyCheck(4'h8, 8'hA5, 8'h00, 1'b1, "R7");
    applyCheck(4'h8, 8'h00, 8'h77, 1'b0, "R7");
    applyCheck(4'hF, 8'h3C, 8'h99, 1'b1, "R9");
    applyCheck(4'h9, 8'h00, 8'hFF, 1'b0, "R9");

    // R10: carry in has no effect on add/subtract
    for (int k = 0; k < 40; k++) begin
      rA = 8'($urandom); rB = 8'($urandom); rOp = 4'(k % 2);
      @(negedge clk);
      opSel = rOp; operandA = rA; operandB = rB; carryIn = 1'b0;
      #2;
      keep0 = {carryOut, result};
      @(negedge clk);
      carryIn = 1'b1;
      #2;
      checks++;
      if ({carryOut, result} !== keep0) begin
        errors++;
        $display("FAIL R10 op=%h a=%h b=%h: got %h with cin=1, expected %h",
                 rOp, rA, rB, {carryOut, result}, keep0);
      end
    end

    // random sweep over all codes, with operand B changing under A-only ops (R4, R7, R9)
    for (int i = 0; i < 3000; i++) begin
      rOp = 4'($urandom); rA = 8'($urandom); rB = 8'($urandom); rC = 1'($urandom);
      if (i % 16 == 0) rA = 8'h00;
      applyCheck(rOp, rA, rB, rC, reqOf(rOp));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule